// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the 64-bit control registers that privileged code inside a processor core reads and writes. A combinational read port and a clocked write port are each addressed by a 6-bit register index. Every index has its own write behaviour: some registers take the whole 64-bit word, some keep only certain bits, some clear on any write, some are read-only, some are write-only, and some are commands whose write is mainly a trigger. An access that a register does not support raises a fault in the same cycle and has no effect.

Command registers produce one-cycle strobes toward the instruction-side and data-side translation buffers: invalidate everything, invalidate per process, invalidate one address, and insert an entry. Each strobe comes with the address-space number (ASN) of its side, an address, and a packed page table entry where that applies. A free-running 32-bit cycle counter is merged into reads of the cycle counter register. The data-side page table entry is rebuilt from its fields when it is read back.

Top module: `ctl_reg_bank`

## Requirements
- R1: Indices 0..21 (scratch), 22 (handler base) and 23 (performance counter) store all 64 written bits, and a read returns them unchanged.
- R2: A write to index 30 (exception address) stores the data with bit 1 forced to zero.
- R3: Index 31 (AST request) and index 32 (AST enable) keep bits 3:0. Index 33 (interrupt level) keeps bits 4:0. Index 34 (instruction mode) and index 35 (data mode) keep only the bits of mask 0x18. All other bits read back as zero.
- R4: These indices store the write data ANDed with a mask: 37 with 0x7fff0, 38 with 0xffffff0300, 39 and 40 with 0xffffffffc0000000, 41 with 0x1ffb, 42 and 43 with 0x3f, 44 (instruction ASN, ASN = bits 10:4) with 0x7f0, and 45 (data ASN, ASN = bits 63:57) with 0xfe00000000000000.
- R5: Any write to index 46 (exception summary) or index 47 (exception mask) leaves that register at zero, whatever the data.
- R6: Any write to index 28 (counter control) leaves that register at 1.
- R7: A write to read-only index 48, 49, 50, 25 or 26 asserts wr_fault in that cycle and changes nothing. A read of write-only index 24, 36, 51..60, 62 or 63 asserts rd_fault and returns zero. Index 27 is undefined and faults on both a read and a write. rd_data is zero whenever rd_en is low.
- R8: A write to index 55/56 (data invalidate all/process) or 58/59 (instruction invalidate all/process) stores zero and raises the matching flush strobe for exactly the cycle after the write, with tb_asn set to that side's ASN. A write to index 57 or 60 (invalidate one) stores the data and raises d_flush_one or i_flush_one, with tb_addr equal to the data and tb_asn equal to the side's ASN. At most one strobe is high in any cycle.
- R9: A write to index 62 (data tag) raises d_insert in the next cycle, with tb_addr equal to the data, tb_asn equal to the data ASN, and tb_pte equal to the index-61 readback of R11. A write to index 63 (instruction entry) raises i_insert, with tb_addr equal to index 24 (instruction tag), tb_asn equal to the instruction ASN, and tb_pte packed from the written data as in R11 but with bits 15:12 zero and the instruction ASN.
- R10: A read of index 29 (cycle counter) returns the stored bits 63:32 above a 32-bit counter that increases by one every clock after reset.
- R11: Index 61 stores a raw 64-bit word. Its read returns only these fields, kept at their raw positions: bits 58:32 (page number), 15:12 (write enables), 11:8 (read enables), 4, 2 and 1. The data ASN is ORed into bits 63:57, and all other bits are zero.
- R12: After reset every register, the counter and every strobe are zero. A read and a write to the same index in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read request |
| rd_idx | input | 6 | Read register index |
| rd_data | output | 64 | Read value (combinational) |
| rd_fault | output | 1 | Illegal read in this cycle |
| wr_en | input | 1 | Write request |
| wr_idx | input | 6 | Write register index |
| wr_data | input | 64 | Write value |
| wr_fault | output | 1 | Illegal write in this cycle |
| d_flush_all | output | 1 | Data-side invalidate-all strobe |
| d_flush_proc | output | 1 | Data-side invalidate-process strobe |
| d_flush_one | output | 1 | Data-side invalidate-address strobe |
| d_insert | output | 1 | Data-side insert strobe |
| i_flush_all | output | 1 | Instruction-side invalidate-all strobe |
| i_flush_proc | output | 1 | Instruction-side invalidate-process strobe |
| i_flush_one | output | 1 | Instruction-side invalidate-address strobe |
| i_insert | output | 1 | Instruction-side insert strobe |
| tb_addr | output | 64 | Address or tag carried by a strobe |
| tb_asn | output | 7 | ASN carried by a strobe |
| tb_pte | output | 64 | Packed page table entry carried by an insert |

## Verification
The assertions assume that at most one write arrives per cycle, which the single write port enforces. They also assume that reset is held long enough to clear the state before any access. The assertions place no constraint on write data or indices, so the stimulus covers the undefined index, every access class, and all-ones data that exposes each mask. Inputs change only at falling edges, so each write and each same-cycle read/write pair is seen whole at one rising edge.

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank #(
  parameter int DW = 64,
  parameter int IW = 6,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          rd_fault,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  output logic          wr_fault,
  output logic          d_flush_all,
  output logic          d_flush_proc,
  output logic          d_flush_one,
  output logic          d_insert,
  output logic          i_flush_all,
  output logic          i_flush_proc,
  output logic          i_flush_one,
  output logic          i_insert,
  output logic [DW-1:0] tb_addr,
  output logic [6:0]    tb_asn,
  output logic [DW-1:0] tb_pte
);
  localparam int NREG = 1 << IW;
  localparam logic [IW-1:0]
    IX_ITAG = 24, IX_IPTE_TMP = 25, IX_DPTE_TMP = 26, IX_CC_CTL = 28, IX_CC = 29,
    IX_EXC_ADDR = 30, IX_AST_REQ = 31, IX_AST_EN = 32, IX_IPL = 33, IX_IMODE = 34,
    IX_DMODE = 35, IX_ALTMODE = 36, IX_SWINT = 37, IX_ICTL = 38, IX_IVPTB = 39,
    IX_DVPTB = 40, IX_DCTEST = 41, IX_DCMODE = 42, IX_MAFMODE = 43, IX_IASN = 44,
    IX_DASN = 45, IX_EXCSUM = 46, IX_EXCMASK = 47, IX_INTID = 48, IX_SERRCV = 49,
    IX_MMSTAT = 50, IX_HWCLR = 51, IX_SERXMT = 52, IX_DCFL = 53, IX_ICFL = 54,
    IX_DINV_ALL = 55, IX_DINV_PROC = 56, IX_DINV_ONE = 57, IX_IINV_ALL = 58,
    IX_IINV_PROC = 59, IX_IINV_ONE = 60, IX_DPTE = 61, IX_DTAG = 62, IX_IPTE = 63,
    IX_UNDEF = 27;

  logic [DW-1:0] regs_q [NREG];
  logic [CW-1:0] cyc_q;

  function automatic logic [DW-1:0] wmask(input logic [IW-1:0] i);
    case (i)
      IX_EXC_ADDR:          wmask = ~64'h2;
      IX_AST_REQ, IX_AST_EN: wmask = 64'hf;
      IX_IPL:               wmask = 64'h1f;
      IX_IMODE, IX_DMODE, IX_ALTMODE: wmask = 64'h18;
      IX_SWINT:             wmask = 64'h7fff0;
      IX_ICTL:              wmask = 64'hff_ffff_0300;
      IX_IVPTB, IX_DVPTB:   wmask = 64'hffff_ffff_c000_0000;
      IX_DCTEST:            wmask = 64'h1ffb;
      IX_DCMODE, IX_MAFMODE: wmask = 64'h3f;
      IX_IASN:              wmask = 64'h7f0;
      IX_DASN:              wmask = 64'hfe00_0000_0000_0000;
      default:              wmask = '1;
    endcase
  endfunction

  function automatic logic can_rd(input logic [IW-1:0] i);
    case (i)
      IX_ITAG, IX_UNDEF, IX_ALTMODE, IX_HWCLR, IX_SERXMT, IX_DCFL, IX_ICFL,
      IX_DINV_ALL, IX_DINV_PROC, IX_DINV_ONE, IX_IINV_ALL, IX_IINV_PROC,
      IX_IINV_ONE, IX_DTAG, IX_IPTE: can_rd = 1'b0;
      default: can_rd = 1'b1;
    endcase
  endfunction

  function automatic logic can_wr(input logic [IW-1:0] i);
    case (i)
      IX_UNDEF, IX_INTID, IX_SERRCV, IX_MMSTAT, IX_IPTE_TMP, IX_DPTE_TMP: can_wr = 1'b0;
      default: can_wr = 1'b1;
    endcase
  endfunction

  function automatic logic [DW-1:0] pte_pack(input logic [DW-1:0] raw,
                                             input logic [6:0] asn, input logic keep_we);
    logic [DW-1:0] p;
    p = '0;
    p[58:32] = raw[58:32];
    p[11:8]  = raw[11:8];
    p[15:12] = keep_we ? raw[15:12] : 4'h0;
    p[1]     = raw[1];
    p[2]     = raw[2];
    p[4]     = raw[4];
    p[63:57] = p[63:57] | asn;
    return p;
  endfunction

  wire [6:0]    d_asn  = regs_q[IX_DASN][63:57];
  wire [6:0]    i_asn  = regs_q[IX_IASN][10:4];
  wire [DW-1:0] d_pte  = pte_pack(regs_q[IX_DPTE], d_asn, 1'b1);
  wire          rd_ok  = can_rd(rd_idx);
  wire          wr_ok  = can_wr(wr_idx);
  wire          wr_go  = wr_en && wr_ok;

  assign rd_fault = rd_en && !rd_ok;
  assign wr_fault = wr_en && !wr_ok;

  always_comb begin
    if (!rd_en || !rd_ok)       rd_data = '0;
    else if (rd_idx == IX_CC)   rd_data = {regs_q[IX_CC][DW-1:32], cyc_q};
    else if (rd_idx == IX_DPTE) rd_data = d_pte;
    else                        rd_data = regs_q[rd_idx];
  end

  logic [DW-1:0] wr_next;
  always_comb begin
    case (wr_idx)
      IX_EXCSUM, IX_EXCMASK, IX_DINV_ALL, IX_DINV_PROC,
      IX_IINV_ALL, IX_IINV_PROC: wr_next = '0;
      IX_CC_CTL:                 wr_next = 64'd1;
      default:                   wr_next = wr_data & wmask(wr_idx);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) regs_q[k] <= '0;
      cyc_q <= '0;
    end else begin
      cyc_q <= cyc_q + 1'b1;
      if (wr_go) regs_q[wr_idx] <= wr_next;
    end
  end

  always_ff @(posedge clk) begin
    {d_flush_all, d_flush_proc, d_flush_one, d_insert} <= '0;
    {i_flush_all, i_flush_proc, i_flush_one, i_insert} <= '0;
    tb_addr <= '0;
    tb_asn  <= '0;
    tb_pte  <= '0;
    if (rst_n && wr_go) begin
      case (wr_idx)
        IX_DINV_ALL:  begin d_flush_all  <= 1'b1; tb_asn <= d_asn; end
        IX_DINV_PROC: begin d_flush_proc <= 1'b1; tb_asn <= d_asn; end
        IX_DINV_ONE:  begin d_flush_one  <= 1'b1; tb_asn <= d_asn; tb_addr <= wr_data; end
        IX_IINV_ALL:  begin i_flush_all  <= 1'b1; tb_asn <= i_asn; end
        IX_IINV_PROC: begin i_flush_proc <= 1'b1; tb_asn <= i_asn; end
        IX_IINV_ONE:  begin i_flush_one  <= 1'b1; tb_asn <= i_asn; tb_addr <= wr_data; end
        IX_DTAG: begin
          d_insert <= 1'b1; tb_asn <= d_asn; tb_addr <= wr_data; tb_pte <= d_pte;
        end
        IX_IPTE: begin
          i_insert <= 1'b1; tb_asn <= i_asn; tb_addr <= regs_q[IX_ITAG];
          tb_pte <= pte_pack(wr_data, i_asn, 1'b0);
        end
        default: ;
      endcase
    end
  end

  p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cyc_q == $past(cyc_q) + 1'b1);
  p_one_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({d_flush_all, d_flush_proc, d_flush_one, d_insert,
              i_flush_all, i_flush_proc, i_flush_one, i_insert}));
  p_inv_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IX_DINV_ALL) |=> d_flush_all && tb_asn == $past(d_asn));
  p_fault_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fault |-> rd_data == '0);
  p_ro_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IX_INTID) |=> $stable(regs_q[IX_INTID]));
  p_excaddr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_idx == IX_EXC_ADDR) |-> !rd_data[1]);
  p_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IX_EXCSUM) |=> regs_q[IX_EXCSUM] == '0);
endmodule

// File: tb/sim_ctl_reg_bank.sv
module sim_ctl_reg_bank;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [5:0] rd_idx = '0, wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data, tb_addr, tb_pte;
  logic [6:0] tb_asn;
  logic rd_fault, wr_fault;
  logic d_flush_all, d_flush_proc, d_flush_one, d_insert;
  logic i_flush_all, i_flush_proc, i_flush_one, i_insert;

  always #4 clk = ~clk;

  ctl_reg_bank u0 (.*);

  int n_chk = 0, n_bad = 0;
  logic [7:0]  s_vec;
  logic [63:0] s_addr, s_pte;
  logic [6:0]  s_asn;
  logic        s_wf;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] i, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_data = d;
    #1 s_wf = wr_fault;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    s_vec  = {d_flush_all, d_flush_proc, d_flush_one, d_insert,
              i_flush_all, i_flush_proc, i_flush_one, i_insert};
    s_addr = tb_addr; s_asn = tb_asn; s_pte = tb_pte;
  endtask

  task automatic rd(input logic [5:0] i, output logic [63:0] d, output logic f);
    @(negedge clk);
    rd_en = 1'b1; rd_idx = i;
    #1 d = rd_data; f = rd_fault;
    rd_en = 1'b0;
  endtask

  localparam int NV = 23;
  localparam logic [137:0] VT [NV] = '{
    {4'd1, 6'd3,  64'hdead_beef_cafe_f00d, 64'hdead_beef_cafe_f00d},   // R1
    {4'd1, 6'd21, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff},   // R1
    {4'd1, 6'd22, 64'h0123_4567_89ab_cdef, 64'h0123_4567_89ab_cdef},   // R1
    {4'd1, 6'd23, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001},   // R1
    {4'd2, 6'd30, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_fffd},   // R2
    {4'd3, 6'd31, 64'h0000_0000_0000_00ff, 64'h0000_0000_0000_000f},   // R3
    {4'd3, 6'd32, 64'h0000_0000_0000_0123, 64'h0000_0000_0000_0003},   // R3
    {4'd3, 6'd33, 64'h0000_0000_0000_00ff, 64'h0000_0000_0000_001f},   // R3
    {4'd3, 6'd34, 64'hffff_ffff_ffff_ffff, 64'h0000_0000_0000_0018},   // R3
    {4'd3, 6'd35, 64'h0000_0000_0000_0008, 64'h0000_0000_0000_0008},   // R3
    {4'd4, 6'd37, 64'hffff_ffff_ffff_ffff, 64'h0000_0000_0007_fff0},   // R4
    {4'd4, 6'd38, 64'hffff_ffff_ffff_ffff, 64'h0000_00ff_ffff_0300},   // R4
    {4'd4, 6'd39, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_c000_0000},   // R4
    {4'd4, 6'd40, 64'h1234_5678_9abc_def0, 64'h1234_5678_8000_0000},   // R4
    {4'd4, 6'd41, 64'hffff_ffff_ffff_ffff, 64'h0000_0000_0000_1ffb},   // R4
    {4'd4, 6'd42, 64'h0000_0000_0000_00ff, 64'h0000_0000_0000_003f},   // R4
    {4'd4, 6'd43, 64'h0000_0000_0000_0041, 64'h0000_0000_0000_0001},   // R4
    {4'd4, 6'd44, 64'h0000_0000_0000_ffff, 64'h0000_0000_0000_07f0},   // R4
    {4'd4, 6'd45, 64'hffff_ffff_ffff_ffff, 64'hfe00_0000_0000_0000},   // R4
    {4'd5, 6'd46, 64'hffff_ffff_ffff_ffff, 64'h0000_0000_0000_0000},   // R5
    {4'd5, 6'd47, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000},   // R5
    {4'd6, 6'd28, 64'h0000_0000_0000_0055, 64'h0000_0000_0000_0001},   // R6
    {4'd1, 6'd0,  64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000}    // R1
  };

  initial begin
    #(8 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] d, d2;
    logic f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    rd(6'd3, d, f);  chk("R12 reset reg", d, 64'h0);
    rd(6'd30, d, f); chk("R12 reset reg", d, 64'h0);
    chk("R12 reset strobes", {56'h0, d_flush_all, d_flush_proc, d_flush_one, d_insert,
        i_flush_all, i_flush_proc, i_flush_one, i_insert}, 64'h0);

    for (int v = 0; v < NV; v++) begin
      wr(VT[v][133:128], VT[v][127:64]);
      chk($sformatf("R%0d wfault", VT[v][137:134]), {63'h0, s_wf}, 64'h0);
      rd(VT[v][133:128], d, f);
      chk($sformatf("R%0d idx %0d", VT[v][137:134], VT[v][133:128]), d, VT[v][63:0]);
    end

    // R7 read-only, write-only, undefined
    wr(6'd48, 64'h1234); chk("R7 ro wfault", {63'h0, s_wf}, 64'h1);
    rd(6'd48, d, f); chk("R7 ro unchanged", d, 64'h0); chk("R7 ro rd ok", {63'h0, f}, 64'h0);
    wr(6'd26, 64'hff); chk("R7 pte tmp wfault", {63'h0, s_wf}, 64'h1);
    wr(6'd51, 64'hffff); chk("R7 wo no strobe", {56'h0, s_vec}, 64'h0);
    rd(6'd51, d, f); chk("R7 wo rfault", {63'h0, f}, 64'h1); chk("R7 wo zero", d, 64'h0);
    rd(6'd36, d, f); chk("R7 altmode rfault", {63'h0, f}, 64'h1);
    rd(6'd27, d, f); chk("R7 undef rfault", {63'h0, f}, 64'h1); chk("R7 undef zero", d, 64'h0);
    wr(6'd27, 64'h1); chk("R7 undef wfault", {63'h0, s_wf}, 64'h1);
    @(negedge clk); #1 chk("R7 idle rd zero", rd_data, 64'h0);

    // ASN setup for R8/R9
    wr(6'd45, 64'hb400_0000_0000_0000);
    wr(6'd44, 64'h0000_0000_0000_02c0);

    // R8 flush strobes
    wr(6'd55, 64'hffff);
    chk("R8 d all strobe", {56'h0, s_vec}, 64'h80); chk("R8 d all asn", {57'h0, s_asn}, 64'h5a);
    @(negedge clk); #1 chk("R8 one cycle", {63'h0, d_flush_all}, 64'h0);
    rd(6'd55, d, f); chk("R8 inv rd faults", {63'h0, f}, 64'h1);
    wr(6'd56, 64'h1); chk("R8 d proc strobe", {56'h0, s_vec}, 64'h40);
    wr(6'd57, 64'h0000_1234_5678_0000);
    chk("R8 d one strobe", {56'h0, s_vec}, 64'h20);
    chk("R8 d one addr", s_addr, 64'h0000_1234_5678_0000);
    chk("R8 d one asn", {57'h0, s_asn}, 64'h5a);
    wr(6'd58, 64'h7); chk("R8 i all strobe", {56'h0, s_vec}, 64'h08);
    chk("R8 i all asn", {57'h0, s_asn}, 64'h2c);
    wr(6'd59, 64'h7); chk("R8 i proc strobe", {56'h0, s_vec}, 64'h04);
    wr(6'd60, 64'h0000_0000_00ab_c000);
    chk("R8 i one strobe", {56'h0, s_vec}, 64'h02);
    chk("R8 i one addr", s_addr, 64'h0000_0000_00ab_c000);

    // R11 data PTE readback
    wr(6'd61, 64'hffff_ffff_ffff_ffff);
    rd(6'd61, d, f); chk("R11 pte all ones", d, 64'hb7ff_ffff_0000_ff16);
    wr(6'd61, 64'h0000_0003_0000_5312);
    rd(6'd61, d, f); chk("R11 pte fields", d, 64'hb400_0003_0000_5312);

    // R9 inserts
    wr(6'd62, 64'h0000_0000_0042_0000);
    chk("R9 d insert", {56'h0, s_vec}, 64'h10);
    chk("R9 d tag", s_addr, 64'h0000_0000_0042_0000);
    chk("R9 d asn", {57'h0, s_asn}, 64'h5a);
    chk("R9 d pte", s_pte, 64'hb400_0003_0000_5312);
    wr(6'd24, 64'h0000_0000_7654_0000);
    wr(6'd63, 64'hffff_ffff_ffff_ffff);
    chk("R9 i insert", {56'h0, s_vec}, 64'h01);
    chk("R9 i tag", s_addr, 64'h0000_0000_7654_0000);
    chk("R9 i asn", {57'h0, s_asn}, 64'h2c);
    chk("R9 i pte", s_pte, 64'h5fff_ffff_0000_0f16);

    // R10 cycle counter merge
    wr(6'd29, 64'haaaa_bbbb_1234_5678);
    rd(6'd29, d, f);
    repeat (9) @(negedge clk);
    rd(6'd29, d2, f);
    chk("R10 upper", {32'h0, d[63:32]}, 64'haaaa_bbbb);
    chk("R10 step", {32'h0, d2[31:0] - d[31:0]}, 64'd10);

    // R12 same-cycle read and write
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'd5; wr_data = 64'h1111;
    rd_en = 1'b1; rd_idx = 6'd5;
    #1 chk("R12 rd old value", rd_data, 64'h0);
    @(negedge clk);
    wr_en = 1'b0;
    #1 chk("R12 rd new value", rd_data, 64'h1111);
    rd_en = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule